// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Unit

This block counts activity for a processor cluster. It holds a parameterised number of 32-bit event counters and one free-running 64-bit cycle counter. Each event counter is bound by software to one of 64 event codes. It advances by one on every clock in which the matching bit of the event input vector is high. Event inputs are single-cycle pulses indexed by event code.

Software reaches the unit through a simple word-addressed read/write port. A read returns its data one cycle after the request. The port is used to program event types, to switch counting on globally and per counter, to preset counter values, and to collect overflow status. Every per-counter mask uses one bit position per counter: event counters sit at bits 0 to N-1 and the cycle counter always sits at bit 31. A level interrupt reports any overflow whose interrupt enable is set.

Register word addresses: 0 control, 1 enable-set (reads the enable mask), 2 enable-clear (reads the enable mask), 3 irq-enable-set (reads the irq-enable mask), 4 irq-enable-clear (reads the irq-enable mask), 5 overflow status, 6 counter select, 7 event type of the selected counter, 8 value of the selected counter, 9 cycle counter bits 31:0, 10 cycle counter bits 63:32, 11 implemented-event map bits 31:0, 12 implemented-event map bits 63:32.

Top module: `clu_pmu`

## Requirements
- R1: After reset all counters, the enable, irq-enable and overflow masks, and the global enable are zero, and irq_o is low.
- R2: A read of the control register (address 0) returns the global enable in bit 0, zero in bits 10:1, NUM_CNT in bits 15:11, ID_CODE in bits 23:16 and IMP_CODE in bits 31:24. The data appears on rdata_o one clock after the request.
- R3: Event counter i advances by one on each clock in which evt_i[type_i] is high, the global enable is set and enable bit i is set; otherwise it holds.
- R4: The 64-bit cycle counter advances once per clock while the global enable and enable bit 31 are both set. It is read and written as two halves at addresses 9 (low) and 10 (high).
- R5: An event counter programmed with event code 0x11 (cycles) never advances. That code only drives the cycle counter.
- R6: A write to a counter value loads it, and counting resumes from the loaded value.
- R7: An event counter advancing from 0xFFFFFFFF wraps to 0 and sets its overflow bit. The cycle counter sets bit 31 when it wraps from all ones.
- R8: A read of the overflow register (address 5) returns the overflow bits and clears them. An overflow that arises in the same clock remains set.
- R9: irq_o is high exactly while some overflow bit and its matching irq-enable bit are both set, and it stays high until the status is cleared.
- R10: Writing control with bit 1 set zeroes all event counters, and with bit 2 set zeroes the cycle counter. Both bits act as one-cycle pulses and read back as zero.
- R11: With the select at an index that is not an implemented event counter (index 31 included), the event-type and counter accesses read zero and ignore writes. Mask bits for counters that do not exist read as zero.
- R12: Addresses 11 and 12 return the low and high halves of the CEID_MAP parameter, in which bit k marks common event code k as implemented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| evt_i | input | 64 | Event pulses indexed by event code |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
Two counters are bound to different codes and driven first with separate pulses and then with a simultaneous pulse. This shows that each counter looks only at its own code and that a shared cycle adds to both. The same pulses are then repeated with the global enable off, and again with one counter's own enable off, which separates the two gating terms. A counter bound to the cycles code receives its event to show that the code is ignored on the event path. Counters preset just below their maximum expose the wrap, the overflow status, the irq gating and the clear-on-read. An exact enable window on the cycle counter pins down its count per clock.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned EVT_W  = 6;
  localparam int unsigned NUM_EVT = 1 << EVT_W;
  localparam int unsigned CYC_IDX = 31;
  localparam logic [EVT_W-1:0] EV_CYCLES = 6'h11;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL    = 4'd0,
    A_EN_SET  = 4'd1,
    A_EN_CLR  = 4'd2,
    A_IE_SET  = 4'd3,
    A_IE_CLR  = 4'd4,
    A_OVF     = 4'd5,
    A_SEL     = 4'd6,
    A_EVTYPE  = 4'd7,
    A_EVCNT   = 4'd8,
    A_CYC_LO  = 4'd9,
    A_CYC_HI  = 4'd10,
    A_CEID_LO = 4'd11,
    A_CEID_HI = 4'd12
  } reg_addr_e;
endpackage

// File: rtl/pmu_evt_cnt.sv
module pmu_evt_cnt
  import pmu_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               type_we_i,
  input  logic [EVT_W-1:0]   type_i,
  input  logic               cnt_we_i,
  input  logic [CW-1:0]      cnt_i,
  input  logic               clr_i,
  output logic [EVT_W-1:0]   type_o,
  output logic [CW-1:0]      cnt_o,
  output logic               wrap_o
);
  logic [EVT_W-1:0] type_q;
  logic [CW-1:0]    cnt_q;
  logic             hit;

  // cycles code is reserved for the dedicated cycle counter
  assign hit = run_i && evt_i[type_q] && (type_q != EV_CYCLES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) type_q <= '0;
    else if (type_we_i) type_q <= type_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= cnt_i;
    else if (hit)      cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = hit && !clr_i && !cnt_we_i && (&cnt_q);
  assign type_o = type_q;
  assign cnt_o  = cnt_q;

  p_hold_when_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i && !clr_i) |=> $stable(cnt_o));
  p_no_cycles_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_o == EV_CYCLES && !cnt_we_i && !clr_i && !type_we_i) |=> $stable(cnt_o));
  p_wrap_to_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0));
endmodule

// File: rtl/pmu_cyc_cnt.sv
module pmu_cyc_cnt #(
  parameter int unsigned CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic [31:0]   wdata_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam int unsigned HW = CW / 2;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (we_lo_i) cnt_q[HW-1:0]  <= wdata_i[HW-1:0];
    else if (we_hi_i) cnt_q[CW-1:HW] <= wdata_i[HW-1:0];
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = run_i && !clr_i && !we_lo_i && !we_hi_i && (&cnt_q);
  assign cnt_o  = cnt_q;

  p_cyc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && !we_lo_i && !we_hi_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_cyc_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/pmu_ovf.sv
module pmu_ovf #(
  parameter int unsigned NB = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] set_i,
  input  logic          rd_clr_i,
  input  logic [NB-1:0] ie_i,
  output logic [NB-1:0] ovf_o,
  output logic          irq_o
);
  logic [NB-1:0] ovf_q;

  // fresh overflows win over the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovf_q <= '0;
    else if (rd_clr_i) ovf_q <= set_i;
    else               ovf_q <= ovf_q | set_i;
  end

  assign ovf_o = ovf_q;
  assign irq_o = |(ovf_q & ie_i);

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr_i |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));
  p_ovf_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && set_i == '0) |=> (ovf_o == '0));
  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_clr_i && $stable(ie_i)) |=> irq_o);
endmodule

// File: rtl/clu_pmu.sv
module clu_pmu
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_CNT  = 6,
  parameter logic [7:0]  ID_CODE  = 8'h41,
  parameter logic [7:0]  IMP_CODE = 8'h5A,
  parameter logic [63:0] CEID_MAP = 64'h0000_1E00_2202_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  localparam int unsigned NB = 32;
  localparam logic [NB-1:0] VALID_MASK = (32'h1 << CYC_IDX) | ((32'h1 << NUM_CNT) - 32'h1);
  localparam logic [4:0] NUM_CNT_F = 5'(NUM_CNT);

  logic        wr, rd;
  logic        glob_en_q;
  logic [NB-1:0] en_q, ie_q;
  logic [4:0]  sel_q;
  logic        ev_clr, cyc_clr;
  logic [31:0] cnt_arr  [NB];
  logic [EVT_W-1:0] type_arr [NB];
  logic [NB-1:0] wrap_vec;
  logic [63:0] cyc_cnt;
  logic [NB-1:0] ovf;
  logic [31:0] rd_val;
  logic [31:0] rdata_q;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  assign ev_clr  = wr && (addr_i == A_CTRL) && wdata_i[1];
  assign cyc_clr = wr && (addr_i == A_CTRL) && wdata_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_en_q <= 1'b0;
      en_q      <= '0;
      ie_q      <= '0;
      sel_q     <= '0;
    end else if (wr) begin
      case (addr_i)
        A_CTRL:   glob_en_q <= wdata_i[0];
        A_EN_SET: en_q  <= en_q | (wdata_i & VALID_MASK);
        A_EN_CLR: en_q  <= en_q & ~wdata_i;
        A_IE_SET: ie_q  <= ie_q | (wdata_i & VALID_MASK);
        A_IE_CLR: ie_q  <= ie_q & ~wdata_i;
        A_SEL:    sel_q <= wdata_i[4:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NB - 1; i++) begin : g_cnt
    if (i < NUM_CNT) begin : g_impl
      pmu_evt_cnt #(.CW(32)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (glob_en_q && en_q[i]),
        .evt_i     (evt_i),
        .type_we_i (wr && (addr_i == A_EVTYPE) && (sel_q == 5'(i))),
        .type_i    (wdata_i[EVT_W-1:0]),
        .cnt_we_i  (wr && (addr_i == A_EVCNT) && (sel_q == 5'(i))),
        .cnt_i     (wdata_i),
        .clr_i     (ev_clr),
        .type_o    (type_arr[i]),
        .cnt_o     (cnt_arr[i]),
        .wrap_o    (wrap_vec[i])
      );
    end else begin : g_none
      assign type_arr[i] = '0;
      assign cnt_arr[i]  = '0;
      assign wrap_vec[i] = 1'b0;
    end
  end
  assign type_arr[CYC_IDX] = '0;
  assign cnt_arr[CYC_IDX]  = '0;

  pmu_cyc_cnt #(.CW(64)) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (glob_en_q && en_q[CYC_IDX]),
    .we_lo_i (wr && (addr_i == A_CYC_LO)),
    .we_hi_i (wr && (addr_i == A_CYC_HI)),
    .wdata_i (wdata_i),
    .clr_i   (cyc_clr),
    .cnt_o   (cyc_cnt),
    .wrap_o  (wrap_vec[CYC_IDX])
  );

  pmu_ovf #(.NB(NB)) u_ovf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (wrap_vec),
    .rd_clr_i (rd && (addr_i == A_OVF)),
    .ie_i     (ie_q),
    .ovf_o    (ovf),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_val = '0;
    case (addr_i)
      A_CTRL:    rd_val = {IMP_CODE, ID_CODE, NUM_CNT_F, 10'b0, glob_en_q};
      A_EN_SET,
      A_EN_CLR:  rd_val = en_q;
      A_IE_SET,
      A_IE_CLR:  rd_val = ie_q;
      A_OVF:     rd_val = ovf;
      A_SEL:     rd_val = {27'b0, sel_q};
      A_EVTYPE:  rd_val = {{(32-EVT_W){1'b0}}, type_arr[sel_q]};
      A_EVCNT:   rd_val = cnt_arr[sel_q];
      A_CYC_LO:  rd_val = cyc_cnt[31:0];
      A_CYC_HI:  rd_val = cyc_cnt[63:32];
      A_CEID_LO: rd_val = CEID_MAP[31:0];
      A_CEID_HI: rd_val = CEID_MAP[63:32];
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  p_mask_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_q & ~VALID_MASK) == '0) && ((ie_q & ~VALID_MASK) == '0));
  p_ctrl_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_CTRL) |=> (rdata_o[2:1] == 2'b00));
endmodule

// File: tb/tb_clu_pmu.sv
module tb_clu_pmu;
  import pmu_pkg::*;

  localparam int unsigned NUM_CNT = 6;
  localparam logic [31:0] CTRL_EXP = {8'h5A, 8'h41, 5'd6, 10'b0, 1'b0};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] evt_i = '0;
  logic        irq_o;

  int total = 0, bad = 0;
  logic pend = 1'b0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  item_t it;

  always #10 clk_i = ~clk_i;

  clu_pmu #(.NUM_CNT(NUM_CNT)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: result of a read appears one edge after the request
  always @(posedge clk_i) pend <= req_i && !we_i;
  always @(negedge clk_i) begin
    if (pend && q.size() > 0) begin
      it = q.pop_front();
      chk(it.tag, rdata_o, it.exp);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t x;
    x.exp = e; x.tag = tag;
    q.push_back(x);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic pulse(input logic [63:0] m);
    evt_i = m;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 / R2 reset state and identity fields
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rd(A_CTRL, CTRL_EXP, "R2 ctrl after reset");
    rd(A_EN_SET, 32'h0, "R1 enable mask reset");
    rd(A_OVF, 32'h0, "R1 overflow reset");
    rd(A_CYC_LO, 32'h0, "R1 cycle counter reset");
    // R12 implemented-event map
    rd(A_CEID_LO, 32'h2202_0000, "R12 ceid low");
    rd(A_CEID_HI, 32'h0000_1E00, "R12 ceid high");

    // R3 basic counting, two codes
    wr(A_SEL, 0); wr(A_EVTYPE, 32'h19);
    wr(A_SEL, 1); wr(A_EVTYPE, 32'h2A);
    wr(A_SEL, 2); wr(A_EVTYPE, 32'h11);
    wr(A_EN_SET, 32'h7);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, CTRL_EXP | 32'h1, "R2 global enable readback");
    repeat (3) pulse(64'h1 << 6'h19);
    pulse(64'h1 << 6'h2A);
    pulse((64'h1 << 6'h19) | (64'h1 << 6'h2A));
    repeat (2) pulse(64'h1 << 6'h11);
    wr(A_SEL, 0); rd(A_EVCNT, 32'd4, "R3 counter0 count");
    wr(A_SEL, 1); rd(A_EVCNT, 32'd2, "R3 counter1 count");
    wr(A_SEL, 2); rd(A_EVCNT, 32'd0, "R5 cycles code ignored");
    rd(A_EVTYPE, 32'h11, "R5 type readback");

    // R3 gating by global and own enable
    wr(A_CTRL, 32'h0);
    pulse(64'h1 << 6'h19);
    wr(A_SEL, 0); rd(A_EVCNT, 32'd4, "R3 global enable off holds");
    wr(A_CTRL, 32'h1);
    wr(A_EN_CLR, 32'h2);
    pulse(64'h1 << 6'h2A);
    pulse(64'h1 << 6'h19);
    wr(A_SEL, 1); rd(A_EVCNT, 32'd2, "R3 own enable off holds");
    wr(A_SEL, 0); rd(A_EVCNT, 32'd5, "R3 enabled neighbour counts");

    // R6 / R7 / R8 / R9 preset, wrap, irq, read-clear
    wr(A_EVCNT, 32'hFFFF_FFFE);
    rd(A_EVCNT, 32'hFFFF_FFFE, "R6 preset readback");
    repeat (2) pulse(64'h1 << 6'h19);
    rd(A_EVCNT, 32'd0, "R7 wrap to zero");
    chk("R9 irq masked", {31'b0, irq_o}, 32'h0);
    wr(A_IE_SET, 32'h1);
    chk("R9 irq raised", {31'b0, irq_o}, 32'h1);
    idle(2);
    chk("R9 irq holds", {31'b0, irq_o}, 32'h1);
    rd(A_OVF, 32'h1, "R8 overflow read");
    chk("R9 irq dropped after clear", {31'b0, irq_o}, 32'h0);
    rd(A_OVF, 32'h0, "R8 overflow cleared");
    pulse(64'h1 << 6'h19);
    rd(A_EVCNT, 32'd1, "R6 counting resumes");

    // R10 event counter reset pulse
    wr(A_CTRL, 32'h3);
    rd(A_EVCNT, 32'd0, "R10 event reset");
    rd(A_CTRL, CTRL_EXP | 32'h1, "R10 reset bits read zero");

    // R4 exact cycle window: 1 + 5 idle edges
    wr(A_CTRL, 32'h5);
    wr(A_EN_SET, 32'h8000_0000);
    idle(5);
    wr(A_EN_CLR, 32'h8000_0000);
    rd(A_CYC_LO, 32'd6, "R4 cycle count window");
    rd(A_CYC_HI, 32'd0, "R4 cycle count high");
    // R6 / R7 cycle preset and 64-bit wrap
    wr(A_CYC_LO, 32'hFFFF_FFF8);
    wr(A_CYC_HI, 32'hFFFF_FFFF);
    rd(A_CYC_LO, 32'hFFFF_FFF8, "R6 cycle preset low");
    rd(A_CYC_HI, 32'hFFFF_FFFF, "R6 cycle preset high");
    wr(A_EN_SET, 32'h8000_0000);
    idle(20);
    rd(A_OVF, 32'h8000_0000, "R7 cycle overflow bit31");
    wr(A_EN_CLR, 32'h8000_0000);
    wr(A_CTRL, 32'h5);
    rd(A_CYC_LO, 32'd0, "R10 cycle reset low");
    rd(A_CYC_HI, 32'd0, "R10 cycle reset high");

    // R11 invalid indices and masks
    wr(A_SEL, 7);
    wr(A_EVCNT, 32'd9); wr(A_EVTYPE, 32'h19);
    rd(A_EVCNT, 32'd0, "R11 invalid counter reads zero");
    rd(A_EVTYPE, 32'd0, "R11 invalid type reads zero");
    wr(A_SEL, 31);
    wr(A_EVCNT, 32'd9);
    rd(A_EVCNT, 32'd0, "R11 index31 indexed path zero");
    rd(A_CYC_LO, 32'd0, "R11 index31 write ignored");
    wr(A_EN_CLR, 32'hFFFF_FFFF);
    wr(A_EN_SET, 32'hFFFF_FFFF);
    rd(A_EN_SET, 32'h8000_003F, "R11 enable mask valid bits");
    wr(A_EN_CLR, 32'hFFFF_FFFF);

    idle(3);
    if (q.size() != 0) chk("scoreboard drained", 32'(q.size()), 32'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule